// File: doc/BRIEF.md
# Exception Entry State Saver

This block applies the architectural side effects of taking or leaving an exception in a simple in-order core. When the core raises an exception, it presents the exception class, a reason code for program exceptions, the current program counter, the machine state word and a vector base. One clock edge later the block has saved a return address and a trimmed copy of the state word into a save pair. It also presents the handler address and the handler's state word, with a one-cycle strobe that tells the core to load both.

Two save pairs exist. Critical input uses its own pair, and every other class uses the main pair. A return-from-interrupt request reloads the program counter and state word from the main pair. A machine check that arrives while machine-check handling is disabled does not vector. It stops the core in a sticky halted state that only reset clears.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is applied, and until the first request after reset, `redirect`, `msr_wr`, `halted` and all outputs that are words read zero.
- R2: A critical-input exception (code 2) writes return address and saved status into the critical pair (`crit_pc`, `crit_msr`) and leaves the main pair unchanged. Every other taken exception writes only the main pair.
- R3: Alignment (code 4) saves PC minus 4, modulo 2^32. External (3), system call (6), decrementer (7), reset (0), machine check (1) and critical (2) save PC unchanged.
- R4: The state word loaded for the handler has only two bits that can be set. Bit 12 (machine-check enable) copies the incoming bit 12. Bit 0 (little-endian) copies incoming bit 16 (interrupt little-endian). A machine check always clears bit 12.
- R5: The handler address is the class vector ORed with `vec_prefix`. The default vectors are: reset 0x100, machine check 0x200, external 0x500, alignment 0x600, program 0x700, decrementer 0x900, critical 0xA00, system call 0xC00.
- R6: The saved status is the incoming state word ANDed with ~0x783F0000. A program exception (code 5) then ORs in a bit chosen by its reason code: 1 illegal adds 0x00080000, 2 privileged adds 0x00040000, 3 trap adds 0x00020000. Each of these saves PC minus 4.
- R7: Reason 0 (floating-point) is discarded, with no output change, if bit 13 (FP available) is 0 or bits 11 and 8 (FE0, FE1) are both 0. Otherwise it adds 0x00100000. If FE0 differs from FE1 it also adds 0x00010000 and saves PC minus 4. Otherwise it saves PC.
- R8: A reset exception with bit 18 (power-save) set adds 0x00010000 to the saved status and keeps bit 12 in the new state word. With bit 18 clear, it clears bit 12 in the new state word.
- R9: A machine check with incoming bit 12 at 0 sets `halted` and writes nothing else. While halted, all exception and return requests are ignored until reset.
- R10: A return request (`rfi_req` without `exc_req`) loads `redirect_pc` = main saved PC with bits 1:0 cleared, and `msr_next` = main saved status ANDed with ~0x783F0000.
- R11: When `exc_req` and `rfi_req` are high in the same cycle, the exception is processed and the return is ignored, even when the exception is discarded.
- R12: Outputs change on the clock edge that samples the request. `redirect` and `msr_wr` are high for exactly that one following cycle, and only after a request that was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_code | input | 3 | Exception class |
| exc_reason | input | 2 | Program-exception reason |
| rfi_req | input | 1 | One-cycle return-from-interrupt request |
| cur_pc | input | 32 | Current program counter |
| cur_msr | input | 32 | Current machine state word |
| vec_prefix | input | 32 | Vector base ORed into handler addresses |
| redirect | output | 1 | Core must load `redirect_pc` |
| redirect_pc | output | 32 | Handler or return address |
| msr_wr | output | 1 | Core must load `msr_next` |
| msr_next | output | 32 | New machine state word |
| save_pc | output | 32 | Main pair: saved return address |
| save_msr | output | 32 | Main pair: saved status |
| crit_pc | output | 32 | Critical pair: saved return address |
| crit_msr | output | 32 | Critical pair: saved status |
| halted | output | 1 | Checkstop state |

## Verification
The checkstop case is the hardest to reach from the ports. It needs a machine check with the enable bit clear. After it, the bench keeps sending exceptions and returns to show that nothing moves, and then applies reset to show the state clears. The floating-point program case is the next hardest: each combination of the FP, FE0 and FE1 bits selects discard, precise or imprecise handling. The return path can only be observed after an earlier exception has filled the main pair, and that saved address is deliberately not word-aligned. A behavioural model in the bench predicts every output on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned WHY_W      = 2;
  localparam int unsigned NUM_PAIRS  = 2;
  localparam int unsigned PAIR_MAIN  = 0;
  localparam int unsigned PAIR_CRIT  = 1;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;

  // state-word bit positions
  localparam int unsigned BIT_LE  = 0;
  localparam int unsigned BIT_FE1 = 8;
  localparam int unsigned BIT_FE0 = 11;
  localparam int unsigned BIT_ME  = 12;
  localparam int unsigned BIT_FP  = 13;
  localparam int unsigned BIT_ILE = 16;
  localparam int unsigned BIT_POW = 18;

  localparam logic [WORD_W-1:0] SAVE_CLR_MASK = 32'h783F_0000;
  localparam logic [WORD_W-1:0] ST_WAKE       = 32'h0001_0000;
  localparam logic [WORD_W-1:0] ST_FP_EXACT   = 32'h0001_0000;
  localparam logic [WORD_W-1:0] ST_FP         = 32'h0010_0000;
  localparam logic [WORD_W-1:0] ST_ILL        = 32'h0008_0000;
  localparam logic [WORD_W-1:0] ST_PRIV       = 32'h0004_0000;
  localparam logic [WORD_W-1:0] ST_TRAP       = 32'h0002_0000;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_MCHK  = 3'd1,
    EXC_CRIT  = 3'd2,
    EXC_EXT   = 3'd3,
    EXC_ALIGN = 3'd4,
    EXC_PROG  = 3'd5,
    EXC_SYSC  = 3'd6,
    EXC_DECR  = 3'd7
  } exc_code_e;

  typedef enum logic [WHY_W-1:0] {
    WHY_FP   = 2'd0,
    WHY_ILL  = 2'd1,
    WHY_PRIV = 2'd2,
    WHY_TRAP = 2'd3
  } prog_why_e;
endpackage

// File: rtl/exc_status_calc.sv
module exc_status_calc
  import exc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [WHY_W-1:0]  why,
  input  logic [WORD_W-1:0] msr,
  input  logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] ret_pc,
  output logic              drop,
  output logic              stop
);
  exc_code_e c;
  prog_why_e w;
  logic      fe0, fe1, fp_on, fp_live, at_fault;

  always_comb begin
    c        = exc_code_e'(code);
    w        = prog_why_e'(why);
    fe0      = msr[BIT_FE0];
    fe1      = msr[BIT_FE1];
    fp_on    = msr[BIT_FP];
    fp_live  = fp_on && (fe0 || fe1);
    status   = msr & ~SAVE_CLR_MASK;
    at_fault = 1'b0;
    drop     = 1'b0;
    stop     = 1'b0;
    case (c)
      EXC_RESET: if (msr[BIT_POW]) status = status | ST_WAKE;
      EXC_MCHK:  stop = !msr[BIT_ME];
      EXC_ALIGN: at_fault = 1'b1;
      EXC_PROG: begin
        case (w)
          WHY_FP: begin
            drop   = !fp_live;
            status = status | ST_FP;
            if (fe0 != fe1) begin
              status   = status | ST_FP_EXACT;
              at_fault = 1'b1;
            end
          end
          WHY_ILL: begin
            status   = status | ST_ILL;
            at_fault = 1'b1;
          end
          WHY_PRIV: begin
            status   = status | ST_PRIV;
            at_fault = 1'b1;
          end
          default: begin
            status   = status | ST_TRAP;
            at_fault = 1'b1;
          end
        endcase
      end
      default: ;
    endcase
    ret_pc = at_fault ? (pc - WORD_W'(INSN_BYTES)) : pc;
  end
endmodule

// File: rtl/exc_msr_vec.sv
module exc_msr_vec
  import exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_RESET = 32'h0000_0100,
  parameter logic [WORD_W-1:0] VEC_MCHK  = 32'h0000_0200,
  parameter logic [WORD_W-1:0] VEC_CRIT  = 32'h0000_0A00,
  parameter logic [WORD_W-1:0] VEC_EXT   = 32'h0000_0500,
  parameter logic [WORD_W-1:0] VEC_ALIGN = 32'h0000_0600,
  parameter logic [WORD_W-1:0] VEC_PROG  = 32'h0000_0700,
  parameter logic [WORD_W-1:0] VEC_SYSC  = 32'h0000_0C00,
  parameter logic [WORD_W-1:0] VEC_DECR  = 32'h0000_0900
) (
  input  logic [CODE_W-1:0] code,
  input  logic              me_in,
  input  logic              pow_in,
  input  logic              ile_in,
  input  logic [WORD_W-1:0] prefix,
  output logic [WORD_W-1:0] new_msr,
  output logic [WORD_W-1:0] handler
);
  exc_code_e         c;
  logic              me_kill;
  logic [WORD_W-1:0] vec;

  always_comb begin
    c       = exc_code_e'(code);
    me_kill = (c == EXC_MCHK) || ((c == EXC_RESET) && !pow_in);
    new_msr = '0;
    new_msr[BIT_ME] = me_in && !me_kill;
    new_msr[BIT_LE] = ile_in;
    case (c)
      EXC_RESET: vec = VEC_RESET;
      EXC_MCHK:  vec = VEC_MCHK;
      EXC_CRIT:  vec = VEC_CRIT;
      EXC_EXT:   vec = VEC_EXT;
      EXC_ALIGN: vec = VEC_ALIGN;
      EXC_PROG:  vec = VEC_PROG;
      EXC_SYSC:  vec = VEC_SYSC;
      default:   vec = VEC_DECR;
    endcase
    handler = vec | prefix;
  end
endmodule

// File: rtl/exc_save_pair.sv
module exc_save_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] pc_d,
  input  logic [W-1:0] st_d,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] st_q
);
  logic [W-1:0] pc_nx, st_nx;

  always_comb begin
    pc_nx = pc_q;
    st_nx = st_q;
    if (wr_en) begin
      pc_nx = pc_d;
      st_nx = st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      st_q <= '0;
    end else begin
      pc_q <= pc_nx;
      st_q <= st_nx;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_RESET = 32'h0000_0100,
  parameter logic [WORD_W-1:0] VEC_MCHK  = 32'h0000_0200,
  parameter logic [WORD_W-1:0] VEC_CRIT  = 32'h0000_0A00,
  parameter logic [WORD_W-1:0] VEC_EXT   = 32'h0000_0500,
  parameter logic [WORD_W-1:0] VEC_ALIGN = 32'h0000_0600,
  parameter logic [WORD_W-1:0] VEC_PROG  = 32'h0000_0700,
  parameter logic [WORD_W-1:0] VEC_SYSC  = 32'h0000_0C00,
  parameter logic [WORD_W-1:0] VEC_DECR  = 32'h0000_0900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [WHY_W-1:0]  exc_reason,
  input  logic              rfi_req,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_msr,
  input  logic [WORD_W-1:0] vec_prefix,
  output logic              redirect,
  output logic [WORD_W-1:0] redirect_pc,
  output logic              msr_wr,
  output logic [WORD_W-1:0] msr_next,
  output logic [WORD_W-1:0] save_pc,
  output logic [WORD_W-1:0] save_msr,
  output logic [WORD_W-1:0] crit_pc,
  output logic [WORD_W-1:0] crit_msr,
  output logic              halted
);
  localparam logic [WORD_W-1:0] ALIGN_CLR = ~WORD_W'((1 << ALIGN_BITS) - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [WORD_W-1:0] st_val, ret_val, msr_val, hnd_val;
  logic              drop, stop;

  exc_status_calc u_status (
    .code   (exc_code),
    .why    (exc_reason),
    .msr    (cur_msr),
    .pc     (cur_pc),
    .status (st_val),
    .ret_pc (ret_val),
    .drop   (drop),
    .stop   (stop)
  );

  exc_msr_vec #(
    .VEC_RESET(VEC_RESET), .VEC_MCHK(VEC_MCHK), .VEC_CRIT(VEC_CRIT),
    .VEC_EXT(VEC_EXT), .VEC_ALIGN(VEC_ALIGN), .VEC_PROG(VEC_PROG),
    .VEC_SYSC(VEC_SYSC), .VEC_DECR(VEC_DECR)
  ) u_vec (
    .code    (exc_code),
    .me_in   (cur_msr[BIT_ME]),
    .pow_in  (cur_msr[BIT_POW]),
    .ile_in  (cur_msr[BIT_ILE]),
    .prefix  (vec_prefix),
    .new_msr (msr_val),
    .handler (hnd_val)
  );

  logic              take, to_crit;
  logic [NUM_PAIRS-1:0] pair_we;
  logic [WORD_W-1:0] pair_pc [NUM_PAIRS];
  logic [WORD_W-1:0] pair_st [NUM_PAIRS];

  logic              redir_q, redir_d, halt_q, halt_d;
  logic [WORD_W-1:0] rpc_q, rpc_d, rmsr_q, rmsr_d;

  always_comb begin
    to_crit = (exc_code_e'(exc_code) == EXC_CRIT);
    take    = 1'b0;
    redir_d = 1'b0;
    halt_d  = halt_q;
    rpc_d   = rpc_q;
    rmsr_d  = rmsr_q;
    if (!halt_q) begin
      if (exc_req) begin
        if (stop) begin
          halt_d = 1'b1;
        end else if (!drop) begin
          take    = 1'b1;
          redir_d = 1'b1;
          rpc_d   = hnd_val;
          rmsr_d  = msr_val;
        end
      end else if (rfi_req) begin
        redir_d = 1'b1;
        rpc_d   = pair_pc[PAIR_MAIN] & ALIGN_CLR;
        rmsr_d  = pair_st[PAIR_MAIN] & ~SAVE_CLR_MASK;
      end
    end
  end

  always_comb begin
    pair_we            = '0;
    pair_we[PAIR_MAIN] = take && !to_crit;
    pair_we[PAIR_CRIT] = take && to_crit;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    exc_save_pair #(.W(WORD_W)) u_pair (
      .clk   (clk),
      .rst_n (rst_s2),
      .wr_en (pair_we[g]),
      .pc_d  (ret_val),
      .st_d  (st_val),
      .pc_q  (pair_pc[g]),
      .st_q  (pair_st[g])
    );
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      redir_q <= 1'b0;
      halt_q  <= 1'b0;
      rpc_q   <= '0;
      rmsr_q  <= '0;
    end else begin
      redir_q <= redir_d;
      halt_q  <= halt_d;
      rpc_q   <= rpc_d;
      rmsr_q  <= rmsr_d;
    end
  end

  assign redirect    = redir_q;
  assign msr_wr      = redir_q;
  assign redirect_pc = rpc_q;
  assign msr_next    = rmsr_q;
  assign halted      = halt_q;
  assign save_pc     = pair_pc[PAIR_MAIN];
  assign save_msr    = pair_st[PAIR_MAIN];
  assign crit_pc     = pair_pc[PAIR_CRIT];
  assign crit_msr    = pair_st[PAIR_CRIT];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic              rfi_req,
  input logic              redirect,
  input logic [WORD_W-1:0] redirect_pc,
  input logic [WORD_W-1:0] msr_next,
  input logic [WORD_W-1:0] save_pc,
  input logic [WORD_W-1:0] save_msr,
  input logic              halted
);
  localparam logic [WORD_W-1:0] HANDLER_MSR_OK = (WORD_W'(1) << BIT_ME) | (WORD_W'(1) << BIT_LE);

  // R12
  redirect_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(exc_req || rfi_req));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> !redirect);

  // R4
  handler_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && $past(exc_req)) |-> ((msr_next & ~HANDLER_MSR_OK) == '0));

  // R10
  return_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rfi_req && !exc_req && !halted)) |->
      (redirect && (redirect_pc[ALIGN_BITS-1:0] == '0) && ((msr_next & SAVE_CLR_MASK) == '0)));

  // R2
  crit_keeps_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_req && (exc_code == EXC_CRIT) && !halted)) |->
      ($stable(save_pc) && $stable(save_msr)));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_req     (exc_req),
  .exc_code    (exc_code),
  .rfi_req     (rfi_req),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .msr_next    (msr_next),
  .save_pc     (save_pc),
  .save_msr    (save_msr),
  .halted      (halted)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        exc_req = 1'b0, rfi_req = 1'b0;
  logic [2:0]  exc_code = '0;
  logic [1:0]  exc_reason = '0;
  logic [31:0] cur_pc = '0, cur_msr = '0, vec_prefix = '0;
  logic        redirect, msr_wr, halted;
  logic [31:0] redirect_pc, msr_next, save_pc, save_msr, crit_pc, crit_msr;

  always #2 clk = ~clk;

  exc_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_reason(exc_reason), .rfi_req(rfi_req), .cur_pc(cur_pc),
    .cur_msr(cur_msr), .vec_prefix(vec_prefix), .redirect(redirect),
    .redirect_pc(redirect_pc), .msr_wr(msr_wr), .msr_next(msr_next),
    .save_pc(save_pc), .save_msr(save_msr), .crit_pc(crit_pc),
    .crit_msr(crit_msr), .halted(halted)
  );

  localparam logic [31:0] MASK = 32'h783F_0000;
  localparam logic [31:0] ME = 32'h1000, ILE = 32'h1_0000, POW = 32'h4_0000;
  localparam logic [31:0] FP = 32'h2000, FE0 = 32'h800, FE1 = 32'h100;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference model
  bit          m_redir, m_halt;
  logic [31:0] m_rpc, m_msr, m_spc, m_sst, m_cpc, m_cst;
  logic [31:0] st, ret, vec;
  bit          crit, skip, keep_me;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_redir = 0; m_halt = 0; m_rpc = 0; m_msr = 0;
      m_spc = 0; m_sst = 0; m_cpc = 0; m_cst = 0; tag = "R1";
    end else begin
      m_redir = 0;
      tag = "R12";
      if (m_halt) begin
        tag = "R9";
      end else if (exc_req) begin
        st = cur_msr & ~MASK; ret = cur_pc; keep_me = cur_msr[12];
        crit = 0; skip = 0; vec = 0;
        case (exc_code)
          3'd0: begin tag = "R8"; vec = 32'h100;
                  if (cur_msr[18]) st = st + 32'h1_0000; else keep_me = 0; end
          3'd1: begin tag = "R9"; vec = 32'h200; keep_me = 0;
                  if (!cur_msr[12]) begin m_halt = 1; skip = 1; end end
          3'd2: begin tag = "R2"; vec = 32'hA00; crit = 1; end
          3'd3: begin tag = "R4"; vec = 32'h500; end
          3'd4: begin tag = "R3"; vec = 32'h600; ret = cur_pc - 4; end
          3'd5: begin
            vec = 32'h700;
            case (exc_reason)
              2'd0: begin
                tag = "R7";
                if (!cur_msr[13] || (!cur_msr[11] && !cur_msr[8])) skip = 1;
                else begin
                  st = st + 32'h10_0000;
                  if (cur_msr[11] != cur_msr[8]) begin st = st + 32'h1_0000; ret = cur_pc - 4; end
                end
              end
              2'd1: begin tag = "R6"; st = st + 32'h8_0000; ret = cur_pc - 4; end
              2'd2: begin tag = "R6"; st = st + 32'h4_0000; ret = cur_pc - 4; end
              default: begin tag = "R6"; st = st + 32'h2_0000; ret = cur_pc - 4; end
            endcase
          end
          3'd6: begin tag = "R5"; vec = 32'hC00; end
          default: begin tag = "R5"; vec = 32'h900; end
        endcase
        if (rfi_req) tag = "R11";
        if (!skip) begin
          m_redir = 1;
          m_rpc = vec | vec_prefix;
          m_msr = (keep_me ? ME : 32'h0) | (cur_msr[16] ? 32'h1 : 32'h0);
          if (crit) begin m_cpc = ret; m_cst = st; end
          else begin m_spc = ret; m_sst = st; end
        end
      end else if (rfi_req) begin
        tag = "R10";
        m_redir = 1;
        m_rpc = {m_spc[31:2], 2'b00};
        m_msr = m_sst & ~MASK;
      end
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(tag, "redirect", {31'b0, redirect}, {31'b0, m_redir});
      chk(tag, "msr_wr", {31'b0, msr_wr}, {31'b0, m_redir});
      chk(tag, "redirect_pc", redirect_pc, m_rpc);
      chk(tag, "msr_next", msr_next, m_msr);
      chk(tag, "save_pc", save_pc, m_spc);
      chk(tag, "save_msr", save_msr, m_sst);
      chk(tag, "crit_pc", crit_pc, m_cpc);
      chk(tag, "crit_msr", crit_msr, m_cst);
      chk(tag, "halted", {31'b0, halted}, {31'b0, m_halt});
    end
  end

  task automatic go(input bit e, input logic [2:0] c, input logic [1:0] w, input bit r,
                    input logic [31:0] pc, input logic [31:0] msr, input logic [31:0] pre);
    exc_req = e; exc_code = c; exc_reason = w; rfi_req = r;
    cur_pc = pc; cur_msr = msr; vec_prefix = pre;
    @(negedge clk);
    exc_req = 0; rfi_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    #1 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();                                                   // R1
    go(1, 3'd3, 0, 0, 32'h0000_1000, ME | ILE | MASK | 32'h8000, 32'h0); // R4 R5
    idle(1);                                                      // R12
    go(1, 3'd4, 0, 0, 32'h0000_2004, ME, 32'hFFF0_0000);          // R3
    go(1, 3'd4, 0, 0, 32'h0, 32'h0, 32'h0);                       // R3 wrap
    go(1, 3'd5, 1, 0, 32'h0000_3000, ME | 32'hFFFF, 32'h0);       // R6 illegal
    go(1, 3'd5, 2, 0, 32'h0000_3100, ILE, 32'h0);                 // R6 privileged
    go(1, 3'd5, 3, 0, 32'h0000_3200, ME | MASK, 32'h1_0000);      // R6 trap
    go(1, 3'd5, 0, 0, 32'h0000_3300, FP | FE0 | ME, 32'h0);       // R7 precise
    go(1, 3'd5, 0, 0, 32'h0000_3400, FP | FE1, 32'h0);            // R7 precise
    go(1, 3'd5, 0, 0, 32'h0000_3500, FP | FE0 | FE1, 32'h0);      // R7 imprecise
    go(1, 3'd5, 0, 0, 32'h0000_3600, FE0 | FE1 | ME, 32'h0);      // R7 dropped, FP off
    go(1, 3'd5, 0, 0, 32'h0000_3700, FP | ME, 32'h0);             // R7 dropped, FE off
    go(1, 3'd6, 0, 0, 32'h0000_400B, ME | 32'h0030_0000, 32'h0);  // R5 syscall
    go(1, 3'd7, 0, 0, 32'h0000_5000, 32'h0, 32'h0008_0000);       // R5 decrementer
    go(1, 3'd6, 0, 0, 32'h0000_400B, ME | 32'h0030_0003, 32'h0);  // refill main pair
    go(1, 3'd2, 0, 0, 32'h0000_6004, ME | ILE, 32'h0);            // R2 critical
    go(0, 0, 0, 1, 32'h0, 32'h0, 32'h0);                          // R10 return
    go(1, 3'd5, 1, 0, 32'h0000_7007, MASK | 32'hA5, 32'h0);       // main pair holds reason bit
    go(0, 0, 0, 1, 32'h0, 32'h0, 32'h0);                          // R10 clears mask bits
    go(1, 3'd0, 0, 0, 32'h0000_8000, POW | ME, 32'h0);            // R8 wake
    go(1, 3'd0, 0, 0, 32'h0000_8100, ME | ILE, 32'h0);            // R8 cold
    go(1, 3'd1, 0, 0, 32'h0000_9000, ME, 32'h0);                  // R9 enabled
    go(1, 3'd3, 0, 1, 32'h0000_A000, ME, 32'h0);                  // R11
    go(1, 3'd5, 0, 1, 32'h0000_A100, ME, 32'h0);                  // R11 dropped wins
    idle(2);
    go(1, 3'd1, 0, 0, 32'h0000_B000, 32'h0, 32'h0);               // R9 checkstop
    go(1, 3'd3, 0, 0, 32'h0000_B100, ME, 32'h0);                  // R9 ignored
    go(0, 0, 0, 1, 32'h0, 32'h0, 32'h0);                          // R9 ignored
    idle(2);
    do_reset();                                                   // R1 again
    go(1, 3'd7, 0, 0, 32'h0000_C000, ME, 32'h0);                  // R12 after reset
    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule